// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block is the write-side command engine of a parallel NOR flash that follows the classic two-unlock-cycle command protocol. It observes host write cycles, each a byte address plus a data word whose low byte carries the command code. It tracks the unlock handshake and the command cycle, and then carries out word programming, sector erase or whole-array erase on an internal storage array. It also handles unlock bypass, the autoselect mode, query-table entry and the software reset code. Erase runs for a programmable number of clock cycles. During that time a sweep fills the target with all-ones words and every host write is ignored.

The host sees the current command mode, an 8-bit status register, a busy flag and the bypass flag. A raw array read port returns the stored word one clock after an address is presented. The read-data multiplexer that would substitute identification or query data lives outside this block.

Top module: `nor_cmd_seq`

## Requirements
- R1: After synchronous reset, `mode` is 0 (read), `status` is 0x00, `busy` is 0 and `bypass` is 0. Mode codes: 0 read, 1 first unlock seen, 2 command cycle, 3 program pending, 4 autoselect, 5 erase-setup awaiting 0xAA, 6 erase-setup awaiting 0x55, 7 erase-command cycle, 8 erasing, 9 query, 10 and 11 program in progress.
- R2: A write whose low byte is 0xF0 returns the block to mode 0 and clears bypass in every mode except 3 (where it is programmed as data) and modes 8, 10 and 11 (where writes are ignored).
- R3: From mode 0, a write of 0xAA at word offset UNLOCK_A gives mode 1. From mode 1, a write of 0x55 at word offset UNLOCK_B gives mode 2. Any other write in those modes gives mode 0.
- R4: In mode 2, the low byte selects the next mode: 0x20 sets bypass and stays in mode 2, 0x80 gives 5, 0x90 gives 4 and 0xA0 gives 3. Any other value gives mode 0. The offset must equal UNLOCK_A unless bypass is set, and a wrong offset gives mode 0.
- R5: In mode 3, the next write ANDs its data into the addressed word and passes through modes 10 and 11. Two clocks after that write, the word holds the AND result. At the same point, `status` becomes {~data[7], 7'h7F} and the mode becomes 2 if bypass is set, else 0.
- R6: In mode 5 the block needs 0xAA at UNLOCK_A (giving mode 6), then 0x55 at UNLOCK_B (giving mode 7). In mode 7, 0x10 at UNLOCK_A starts an erase of the whole array, and 0x30 at any address starts an erase of the sector holding that address. Either write sets `status` to 0x00, `busy` to 1 and the mode to 8. Any other write in these modes gives mode 0.
- R7: `busy` stays high for exactly SECT_ERASE_CYCLES (sector erase) or CHIP_ERASE_CYCLES (whole-array erase) clocks, each raised to at least one more than the number of words erased. Writes during this time change nothing. At the end, `status` bit 7 inverts, the target words read 0xFFFF, words outside the target keep their values, and the mode becomes 2 with bypass set, else 0.
- R8: A write of 0x98 at word offset 0x55 in mode 0, 4 or 5 gives mode 9. Any write in mode 9 gives mode 0.
- R9: In mode 4 with bypass set, a write of 0x00 clears bypass and gives mode 0.
- R10: The word index is the byte address shifted right by log2(WORD_BYTES) and taken modulo the array size. The offset used for matching unlock addresses is that index modulo SECTOR_WORDS.
- R11: `rd_data` returns the word at the index that `rd_addr` maps to (per R10), one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8*WORD_BYTES | Write data; low byte is the command code |
| rd_addr | input | ADDR_W | Byte address for the raw array read port |
| rd_data | output | 8*WORD_BYTES | Stored word, one clock after rd_addr |
| mode | output | 4 | Current command mode code |
| status | output | 8 | Status register |
| busy | output | 1 | High while an erase is in progress |
| bypass | output | 1 | Unlock bypass active |

## Verification
The bench builds the block with 16-bit words, 128-word sectors, four sectors and a 12-bit byte address. The two extra address bits above the array size make modulo-array aliasing reachable. Offsets one sector higher make modulo-sector unlock matching reachable. The unlock offsets are 0x55 and 0x2A. The erase lengths are 200 and 600 cycles, so the exact end of both erase kinds falls in a short run. Because the whole-array erase outlasts the sector erase, the bench can also tell the two durations apart.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [3:0] {
    M_READ     = 4'd0,
    M_UNLK1    = 4'd1,
    M_CMD      = 4'd2,
    M_PROG     = 4'd3,
    M_AUTOSEL  = 4'd4,
    M_ESET_A   = 4'd5,
    M_ESET_B   = 4'd6,
    M_ESET_CMD = 4'd7,
    M_ERASING  = 4'd8,
    M_QUERY    = 4'd9,
    M_PGM_RD   = 4'd10,
    M_PGM_WR   = 4'd11
  } nor_mode_e;

  localparam logic [7:0] OP_RESET    = 8'hF0;
  localparam logic [7:0] OP_KEY_A    = 8'hAA;
  localparam logic [7:0] OP_KEY_B    = 8'h55;
  localparam logic [7:0] OP_BYPASS   = 8'h20;
  localparam logic [7:0] OP_ESETUP   = 8'h80;
  localparam logic [7:0] OP_AUTOSEL  = 8'h90;
  localparam logic [7:0] OP_PROGRAM  = 8'hA0;
  localparam logic [7:0] OP_CHIP_ER  = 8'h10;
  localparam logic [7:0] OP_SECT_ER  = 8'h30;
  localparam logic [7:0] OP_QUERY    = 8'h98;
  localparam logic [7:0] OP_BYP_EXIT = 8'h00;

  localparam int unsigned QUERY_OFFSET = 'h55;

endpackage

// File: rtl/nor_addr_map.sv
module nor_addr_map #(
  parameter int WORD_BYTES = 2,
  parameter int ADDR_W     = 12,
  parameter int CHIP_WORDS = 512,
  parameter int CW         = $clog2(CHIP_WORDS)
) (
  input  logic [ADDR_W-1:0] byte_addr,
  output logic [CW-1:0]     widx
);
  localparam int BSH = $clog2(WORD_BYTES);

  // Drop the byte lane bits, then wrap modulo the array size.
  assign widx = CW'(byte_addr >> BSH);
endmodule

// File: rtl/nor_store.sv
module nor_store #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 512,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [AW-1:0]     a_addr,
  input  logic [WORD_W-1:0] a_wdata,
  output logic [WORD_W-1:0] a_rdata,
  input  logic [AW-1:0]     b_addr,
  output logic [WORD_W-1:0] b_rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  // Port A: internal read-modify-write and erase sweep, read-first.
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  // Port B: host-side raw read.
  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/nor_erase_engine.sv
module nor_erase_engine #(
  parameter int CHIP_WORDS        = 512,
  parameter int SECTOR_WORDS      = 128,
  parameter int SECT_ERASE_CYCLES = 200,
  parameter int CHIP_ERASE_CYCLES = 600,
  parameter int AW                = $clog2(CHIP_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          chip_sel,
  input  logic [AW-1:0] base,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          done
);
  localparam int SECT_EFF = (SECT_ERASE_CYCLES > SECTOR_WORDS) ? SECT_ERASE_CYCLES : SECTOR_WORDS + 1;
  localparam int CHIP_EFF = (CHIP_ERASE_CYCLES > CHIP_WORDS) ? CHIP_ERASE_CYCLES : CHIP_WORDS + 1;
  localparam int MAX_EFF  = (CHIP_EFF > SECT_EFF) ? CHIP_EFF : SECT_EFF;
  localparam int TW       = $clog2(MAX_EFF);
  localparam int LW       = $clog2(CHIP_WORDS + 1);

  logic          active;
  logic [TW-1:0] tmr;
  logic [LW-1:0] left;
  logic [AW-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      tmr    <= '0;
      left   <= '0;
      ptr    <= '0;
    end else if (start) begin
      active <= 1'b1;
      tmr    <= chip_sel ? TW'(CHIP_EFF - 1) : TW'(SECT_EFF - 1);
      left   <= chip_sel ? LW'(CHIP_WORDS) : LW'(SECTOR_WORDS);
      ptr    <= chip_sel ? '0 : base;
    end else if (active) begin
      if (tmr == '0) active <= 1'b0;
      else           tmr    <= tmr - 1'b1;
      if (left != '0) begin
        left <= left - 1'b1;
        ptr  <= ptr + 1'b1;
      end
    end
  end

  // One word per cycle is swept while the timer runs; the timer is longer.
  assign we    = active && (left != '0);
  assign waddr = ptr;
  assign done  = active && (tmr == '0);
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int WORD_BYTES        = 2,
  parameter int SECTOR_WORDS      = 128,
  parameter int SECTORS           = 4,
  parameter int ADDR_W            = 12,
  parameter int UNLOCK_A          = 'h55,
  parameter int UNLOCK_B          = 'h2A,
  parameter int SECT_ERASE_CYCLES = 50_000_000,
  parameter int CHIP_ERASE_CYCLES = 500_000_000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [8*WORD_BYTES-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [8*WORD_BYTES-1:0] rd_data,
  output logic [3:0]              mode,
  output logic [7:0]              status,
  output logic                    busy,
  output logic                    bypass
);
  import nor_seq_pkg::*;

  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int CHIP_WORDS = SECTOR_WORDS * SECTORS;
  localparam int CW         = $clog2(CHIP_WORDS);
  localparam int SW         = $clog2(SECTOR_WORDS);
  localparam logic [CW-1:0] SEC_MASK = ~CW'(SECTOR_WORDS - 1);
  localparam logic [SW-1:0] OFF_A    = SW'(UNLOCK_A);
  localparam logic [SW-1:0] OFF_B    = SW'(UNLOCK_B);
  localparam logic [SW-1:0] OFF_Q    = SW'(QUERY_OFFSET);

  // Address decode
  logic [CW-1:0] wr_widx, rd_widx;
  logic [SW-1:0] wr_off;

  nor_addr_map #(.WORD_BYTES(WORD_BYTES), .ADDR_W(ADDR_W), .CHIP_WORDS(CHIP_WORDS)) u_wmap (
    .byte_addr(wr_addr), .widx(wr_widx));
  nor_addr_map #(.WORD_BYTES(WORD_BYTES), .ADDR_W(ADDR_W), .CHIP_WORDS(CHIP_WORDS)) u_rmap (
    .byte_addr(rd_addr), .widx(rd_widx));

  assign wr_off = SW'(wr_widx);

  // Registered state
  nor_mode_e         mode_q, mode_d;
  logic              byp_q, byp_d;
  logic [7:0]        stat_q, stat_d;
  logic [CW-1:0]     pg_addr;
  logic [WORD_W-1:0] pg_data;

  // Decode helpers
  logic [7:0] op;
  logic       at_a, at_b, is_query;
  logic       go_idle, pg_load, er_start, er_chip;
  logic       er_we, er_done;
  logic [CW-1:0] er_waddr;

  assign op       = wr_data[7:0];
  assign at_a     = (wr_off == OFF_A);
  assign at_b     = (wr_off == OFF_B);
  assign is_query = (wr_off == OFF_Q) && (op == OP_QUERY);

  always_comb begin
    mode_d   = mode_q;
    byp_d    = byp_q;
    stat_d   = stat_q;
    go_idle  = 1'b0;
    pg_load  = 1'b0;
    er_start = 1'b0;
    er_chip  = 1'b0;
    case (mode_q)
      M_PGM_RD: mode_d = M_PGM_WR;
      M_PGM_WR: begin
        stat_d = {~pg_data[7], 7'h7F};
        mode_d = byp_q ? M_CMD : M_READ;
      end
      M_ERASING: begin
        if (er_done) begin
          stat_d[7] = ~stat_q[7];
          mode_d    = byp_q ? M_CMD : M_READ;
        end
      end
      default: begin
        if (wr_en) begin
          if (op == OP_RESET && mode_q != M_PROG) begin
            go_idle = 1'b1;
          end else begin
            case (mode_q)
              M_READ, M_ESET_A: begin
                if (is_query)                     mode_d = M_QUERY;
                else if (at_a && op == OP_KEY_A)  mode_d = (mode_q == M_READ) ? M_UNLK1 : M_ESET_B;
                else                              go_idle = 1'b1;
              end
              M_UNLK1: begin
                if (at_b && op == OP_KEY_B) mode_d = M_CMD;
                else                        go_idle = 1'b1;
              end
              M_ESET_B: begin
                if (at_b && op == OP_KEY_B) mode_d = M_ESET_CMD;
                else                        go_idle = 1'b1;
              end
              M_CMD: begin
                if (!byp_q && !at_a) go_idle = 1'b1;
                else begin
                  case (op)
                    OP_BYPASS:  byp_d  = 1'b1;
                    OP_ESETUP:  mode_d = M_ESET_A;
                    OP_AUTOSEL: mode_d = M_AUTOSEL;
                    OP_PROGRAM: mode_d = M_PROG;
                    default:    go_idle = 1'b1;
                  endcase
                end
              end
              M_PROG: begin
                pg_load = 1'b1;
                mode_d  = M_PGM_RD;
              end
              M_AUTOSEL: begin
                if (byp_q && op == OP_BYP_EXIT) go_idle = 1'b1;
                else if (is_query)              mode_d  = M_QUERY;
                else                            go_idle = 1'b1;
              end
              M_ESET_CMD: begin
                if (op == OP_CHIP_ER && at_a) begin
                  er_start = 1'b1;
                  er_chip  = 1'b1;
                end else if (op == OP_SECT_ER) begin
                  er_start = 1'b1;
                end else begin
                  go_idle = 1'b1;
                end
                if (er_start) begin
                  stat_d = 8'h00;
                  mode_d = M_ERASING;
                end
              end
              default: go_idle = 1'b1;
            endcase
          end
          if (go_idle) begin
            mode_d = M_READ;
            byp_d  = 1'b0;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= M_READ;
      byp_q   <= 1'b0;
      stat_q  <= 8'h00;
      pg_addr <= '0;
      pg_data <= '0;
    end else begin
      mode_q <= mode_d;
      byp_q  <= byp_d;
      stat_q <= stat_d;
      if (pg_load) begin
        pg_addr <= wr_widx;
        pg_data <= wr_data;
      end
    end
  end

  // Erase sweep and duration timer
  nor_erase_engine #(
    .CHIP_WORDS(CHIP_WORDS), .SECTOR_WORDS(SECTOR_WORDS),
    .SECT_ERASE_CYCLES(SECT_ERASE_CYCLES), .CHIP_ERASE_CYCLES(CHIP_ERASE_CYCLES)
  ) u_erase (
    .clk(clk), .rst(rst), .start(er_start), .chip_sel(er_chip),
    .base(wr_widx & SEC_MASK), .we(er_we), .waddr(er_waddr), .done(er_done));

  // Storage array: port A shared by the program path and the erase sweep
  logic              a_we;
  logic [CW-1:0]     a_addr;
  logic [WORD_W-1:0] a_wdata, a_rdata;

  assign a_we    = er_we || (mode_q == M_PGM_WR);
  assign a_addr  = er_we ? er_waddr : pg_addr;
  assign a_wdata = er_we ? {WORD_W{1'b1}} : (a_rdata & pg_data);

  nor_store #(.WORD_W(WORD_W), .DEPTH(CHIP_WORDS)) u_store (
    .clk(clk), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_addr(rd_widx), .b_rdata(rd_data));

  assign mode   = mode_q;
  assign status = stat_q;
  assign busy   = (mode_q == M_ERASING);
  assign bypass = byp_q;
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] cmd_byte,
  input logic [3:0] mode,
  input logic [7:0] status,
  input logic       busy,
  input logic       bypass
);
  import nor_seq_pkg::*;

  AST_ERASE_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> status == 8'h00) else $error("erase start status"); // R6

  AST_ERASE_END_FLIP: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> status == 8'h80) else $error("erase end status"); // R7

  AST_BUSY_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(status) && $stable(bypass)) else $error("status moved while busy"); // R7

  AST_RESET_CODE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cmd_byte == OP_RESET && mode != M_PROG && mode != M_ERASING &&
     mode != M_PGM_RD && mode != M_PGM_WR) |=> (mode == M_READ && !bypass)) else $error("reset code"); // R2

  AST_QUERY_EXIT: assert property (@(posedge clk) disable iff (rst)
    (mode == M_QUERY && wr_en) |=> mode == M_READ) else $error("query exit"); // R8

  AST_PROG_RET_BYP: assert property (@(posedge clk) disable iff (rst)
    (mode == M_PGM_WR && bypass) |=> (mode == M_CMD && bypass)) else $error("program return bypass"); // R5

  AST_PROG_RET_READ: assert property (@(posedge clk) disable iff (rst)
    (mode == M_PGM_WR && !bypass) |=> mode == M_READ) else $error("program return read"); // R5

  AST_BYPASS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(bypass) |-> mode == M_CMD) else $error("bypass entry"); // R4
endmodule

bind nor_cmd_seq nor_cmd_seq_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .cmd_byte(wr_data[7:0]),
  .mode(mode), .status(status), .busy(busy), .bypass(bypass));

// File: tb/nor_cmd_seq_bench.sv
module nor_cmd_seq_bench;
  localparam int WB     = 2;
  localparam int SW     = 128;
  localparam int NS     = 4;
  localparam int CWORDS = SW * NS;
  localparam int AW     = 12;
  localparam int UA     = 'h55;
  localparam int UB     = 'h2A;
  localparam int SECT   = 200;
  localparam int CHIP   = 600;

  localparam int MD_READ = 0, MD_UNLK1 = 1, MD_CMD = 2, MD_PROG = 3, MD_AUTO = 4;
  localparam int MD_ESA = 5, MD_ESB = 6, MD_ESC = 7, MD_ERASE = 8, MD_QUERY = 9, MD_PGM = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [15:0]   rd_data;
  logic [3:0]    mode;
  logic [7:0]    status;
  logic          busy, bypass;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  nor_cmd_seq #(
    .WORD_BYTES(WB), .SECTOR_WORDS(SW), .SECTORS(NS), .ADDR_W(AW),
    .UNLOCK_A(UA), .UNLOCK_B(UB), .SECT_ERASE_CYCLES(SECT), .CHIP_ERASE_CYCLES(CHIP)
  ) u_nor_cmd_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .mode(mode), .status(status),
    .busy(busy), .bypass(bypass));

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr_byte(input int baddr, input logic [15:0] d);
    @(negedge clk);
    wr_addr = AW'(baddr);
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wr(input int widx, input logic [15:0] d);
    wr_byte(widx * WB, d);
  endtask

  task automatic rd(input int widx, output logic [15:0] v);
    @(negedge clk);
    rd_addr = AW'(widx * WB);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    wr(UA, 16'h00AA);
    wr(UB, 16'h0055);
  endtask

  task automatic program_word(input int widx, input logic [15:0] d);
    unlock();
    wr(UA, 16'h00A0);
    wr(widx, d);
    idle(2);
  endtask

  task automatic t_reset();
    check("R1", "mode", 32'(mode), MD_READ);
    check("R1", "status", 32'(status), 32'h00);
    check("R1", "busy", 32'(busy), 0);
    check("R1", "bypass", 32'(bypass), 0);
  endtask

  task automatic t_chip_erase();
    logic [15:0] v;
    unlock(); wr(UA, 16'h0080); unlock();
    wr(UB, 16'h0010);
    check("R6", "whole erase at wrong offset ignored", 32'(mode), MD_READ);
    check("R6", "no busy after rejected erase", 32'(busy), 0);
    unlock(); wr(UA, 16'h0080);
    check("R4", "erase setup mode", 32'(mode), MD_ESA);
    wr(UA, 16'h00AA);
    check("R6", "second unlock A", 32'(mode), MD_ESB);
    wr(UB, 16'h0055);
    check("R6", "second unlock B", 32'(mode), MD_ESC);
    wr(UA, 16'h0010);
    check("R6", "erase busy", 32'(busy), 1);
    check("R6", "erase status clear", 32'(status), 32'h00);
    idle(CHIP - 1);
    check("R7", "busy held for whole-array length", 32'(busy), 1);
    idle(1);
    check("R7", "busy drops at whole-array length", 32'(busy), 0);
    check("R7", "status bit7 flipped", 32'(status), 32'h80);
    check("R7", "mode back to read", 32'(mode), MD_READ);
    rd(0, v);   check("R11", "word 0 erased", 32'(v), 32'hFFFF);
    rd(300, v); check("R7", "word 300 erased", 32'(v), 32'hFFFF);
    rd(511, v); check("R7", "word 511 erased", 32'(v), 32'hFFFF);
  endtask

  task automatic t_program();
    logic [15:0] v;
    unlock();
    wr(UA, 16'h00A0);
    check("R4", "program pending mode", 32'(mode), MD_PROG);
    wr(5, 16'h1234);
    check("R5", "program in progress", 32'(mode), MD_PGM);
    idle(2);
    check("R5", "mode after program", 32'(mode), MD_READ);
    check("R5", "status bit7 clear data", 32'(status), 32'hFF);
    rd(5, v); check("R5", "first program", 32'(v), 32'h1234);
    program_word(5, 16'hFF0F);
    rd(5, v); check("R5", "program ANDs", 32'(v), 32'h1204);
    program_word(6, 16'h0080);
    check("R5", "status bit7 set data", 32'(status), 32'h7F);
    rd(6, v); check("R5", "word 6", 32'(v), 32'h0080);
  endtask

  task automatic t_unlock_bad();
    wr(UB, 16'h00AA);
    check("R3", "AA at wrong offset", 32'(mode), MD_READ);
    wr(UA, 16'h00AA);
    check("R3", "first unlock", 32'(mode), MD_UNLK1);
    wr(UA, 16'h0055);
    check("R3", "55 at wrong offset", 32'(mode), MD_READ);
    unlock();
    check("R3", "full unlock", 32'(mode), MD_CMD);
    wr(UB, 16'h00A0);
    check("R4", "command at wrong offset", 32'(mode), MD_READ);
    unlock(); wr(UA, 16'h0033);
    check("R4", "unknown command", 32'(mode), MD_READ);
  endtask

  task automatic t_reset_code();
    logic [15:0] v;
    wr(UA, 16'h00AA); wr(7, 16'h00F0);
    check("R2", "F0 after first unlock", 32'(mode), MD_READ);
    unlock(); wr(UA, 16'h0090);
    check("R4", "autoselect mode", 32'(mode), MD_AUTO);
    wr(9, 16'h00F0);
    check("R2", "F0 in autoselect", 32'(mode), MD_READ);
    unlock(); wr(UA, 16'h00A0); wr(10, 16'h00F0);
    check("R2", "F0 programmed as data", 32'(mode), MD_PGM);
    idle(2);
    rd(10, v); check("R2", "word 10 holds F0", 32'(v), 32'h00F0);
  endtask

  task automatic t_query();
    wr('h55, 16'h0098);
    check("R8", "query from read", 32'(mode), MD_QUERY);
    wr(3, 16'h0012);
    check("R8", "query exit", 32'(mode), MD_READ);
    unlock(); wr(UA, 16'h0090); wr('h55, 16'h0098);
    check("R8", "query from autoselect", 32'(mode), MD_QUERY);
    wr(0, 16'h00F0);
    check("R8", "query exit on reset code", 32'(mode), MD_READ);
  endtask

  task automatic t_bypass();
    logic [15:0] v;
    unlock(); wr(UA, 16'h0020);
    check("R4", "bypass set", 32'(bypass), 1);
    check("R4", "bypass mode", 32'(mode), MD_CMD);
    wr(77, 16'h00A0);
    check("R4", "bypass skips offset check", 32'(mode), MD_PROG);
    wr(20, 16'h5A5A);
    idle(2);
    check("R5", "program returns to command cycle", 32'(mode), MD_CMD);
    check("R5", "bypass kept", 32'(bypass), 1);
    check("R5", "status", 32'(status), 32'hFF);
    rd(20, v); check("R5", "bypass program data", 32'(v), 32'h5A5A);
    wr(3, 16'h0090);
    check("R9", "autoselect in bypass", 32'(mode), MD_AUTO);
    wr(3, 16'h0000);
    check("R9", "bypass exit mode", 32'(mode), MD_READ);
    check("R9", "bypass cleared", 32'(bypass), 0);
  endtask

  task automatic t_sector_erase();
    logic [15:0] v;
    program_word(130, 16'h1111);
    program_word(255, 16'h0000);
    program_word(260, 16'h2222);
    unlock(); wr(UA, 16'h0080); unlock();
    wr(200, 16'h0030);
    check("R6", "sector erase busy", 32'(busy), 1);
    idle(10);
    wr(UA, 16'h00F0);
    wr(UA, 16'h00AA);
    check("R7", "writes ignored while erasing", 32'(mode), MD_ERASE);
    check("R7", "status held while erasing", 32'(status), 32'h00);
    idle(SECT - 1 - 14);
    check("R7", "busy held for sector length", 32'(busy), 1);
    idle(1);
    check("R7", "busy drops at sector length", 32'(busy), 0);
    check("R7", "sector erase status", 32'(status), 32'h80);
    rd(130, v); check("R7", "sector word erased", 32'(v), 32'hFFFF);
    rd(255, v); check("R7", "sector last word erased", 32'(v), 32'hFFFF);
    rd(260, v); check("R7", "neighbour sector kept", 32'(v), 32'h2222);
    rd(5, v);   check("R7", "lower sector kept", 32'(v), 32'h1204);
  endtask

  task automatic t_bypass_erase();
    logic [15:0] v;
    unlock(); wr(UA, 16'h0020);
    wr(401, 16'h00A0); wr(401, 16'h0000); idle(2);
    wr(0, 16'h0080);
    check("R4", "bypass erase setup", 32'(mode), MD_ESA);
    unlock();
    wr(400, 16'h0030);
    idle(SECT);
    check("R7", "erase returns to command cycle in bypass", 32'(mode), MD_CMD);
    check("R7", "bypass kept after erase", 32'(bypass), 1);
    rd(401, v); check("R7", "bypass sector erased", 32'(v), 32'hFFFF);
    wr(0, 16'h00F0);
    check("R2", "reset code clears bypass", 32'(bypass), 0);
  endtask

  task automatic t_alias();
    logic [15:0] v;
    wr(UA + SW, 16'h00AA);
    wr(UB + 2 * SW, 16'h0055);
    check("R10", "unlock offsets modulo sector", 32'(mode), MD_CMD);
    wr(UA + 3 * SW, 16'h00A0);
    check("R10", "command offset modulo sector", 32'(mode), MD_PROG);
    wr_byte(CWORDS * WB + 50 * WB + 1, 16'h0F0F);
    idle(2);
    rd(50, v); check("R10", "address modulo array", 32'(v), 32'h0F0F);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_chip_erase();
    t_program();
    t_unlock_bad();
    t_reset_code();
    t_query();
    t_bypass();
    t_sector_erase();
    t_bypass_erase();
    t_alias();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule